// File: doc/BRIEF.md
# Interleaved Fragment Distribution Router

This block sits behind one fragment generator in a parallel rasterizer. The screen is split among five generators by a fine diagonal interleave, so that even a small triangle touches all of them. Each generator's share is split again among sixteen pixel processors. The router takes one fragment per cycle (pixel x, pixel y and an opaque payload) and steers it to the processor that owns that pixel.

Each processor has its own eight-entry queue in front of it, so a burst aimed at one processor does not stall fragments bound for the others. Order is kept within each processor's stream. Order between streams is free, and each output drains under its own ready.

A fragment whose pixel belongs to a different generator is a routing fault upstream. The router takes it, drops it and raises a one-cycle fault pulse.

Top module: `frag_router`

## Requirements
- R1: While reset is held and right after it, every output valid and the fault pulse are low, and input ready is high.
- R2: A fragment is foreign when (x + y) mod 5 differs from the GEN_ID parameter. A foreign fragment is accepted with ready high and is never presented on any output. The fault output is high for exactly the one cycle after it was accepted.
- R3: An owned fragment goes to the output with index ((x / 5) mod 4) + 4 * (y mod 4), using integer division. If that output's queue was empty, the output shows it as valid in the cycle after acceptance.
- R4: Fragments bound for the same output leave it in the order they were accepted. Each leaves with x, y and payload unchanged, packed as {x, y, payload} in that output's slice of out_frag_o.
- R5: Each output queue holds 8 fragments. Input ready is low exactly when the presented fragment is owned and its output queue already holds 8. No fragment is lost or duplicated.
- R6: A full, stalled output does not delay fragments accepted for other outputs.
- R7: While an output is valid and its ready is low, that output stays valid and its fragment is unchanged.
- R8: The fault output never rises after an owned fragment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid_i | input | 1 | Input fragment valid |
| in_ready_o | output | 1 | Input fragment accepted when high together with valid |
| in_x_i | input | X_W | Pixel x coordinate |
| in_y_i | input | Y_W | Pixel y coordinate |
| in_pay_i | input | PAY_W | Fragment payload (colour, depth, coverage) |
| out_valid_o | output | 16 | Per-output fragment valid |
| out_ready_i | input | 16 | Per-output ready from the pixel processors |
| out_frag_o | output | 16*(X_W+Y_W+PAY_W) | Per-output fragment {x, y, payload}; output d uses slice d |
| foreign_o | output | 1 | One-cycle pulse after a foreign fragment is dropped |

## Verification
The hardest condition to reach is one queue sitting full and stalled while an owned fragment for that same output waits at the input, with traffic to other outputs still flowing past it. Random coordinates almost never do this. The stimulus therefore chooses coordinates per target output by search, holds one output's ready low until eight fragments pile up, and keeps offering a ninth. At the same time it pushes fragments to other outputs and drops foreign fragments in between. A behavioural queue model is compared with every output on every cycle, across both the directed phases and a long random phase with random per-output stalls.

// File: rtl/frag_route_pkg.sv
package frag_route_pkg;
  // Screen interleave across generators and the per-generator processor grid
  parameter int unsigned FR_GEN_COUNT = 5;
  parameter int unsigned FR_COLS      = 4;
  parameter int unsigned FR_ROWS      = 4;
  parameter int unsigned FR_DEPTH     = 8;
  parameter int unsigned FR_X_W       = 11;
  parameter int unsigned FR_Y_W       = 10;
  parameter int unsigned FR_PAY_W     = 32;
endpackage

// File: rtl/frag_rst_sync.sv
module frag_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic srst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_no = sync_q[1];
endmodule

// File: rtl/frag_addr_map.sv
module frag_addr_map #(
  parameter int unsigned X_W    = 11,
  parameter int unsigned Y_W    = 10,
  parameter int unsigned NGEN   = 5,
  parameter int unsigned COLS   = 4,
  parameter int unsigned ROWS   = 4,
  parameter int unsigned GEN_ID = 0,
  localparam int unsigned NDST  = COLS * ROWS,
  localparam int unsigned DST_W = (NDST > 1) ? $clog2(NDST) : 1
) (
  input  logic [X_W-1:0]   x_i,
  input  logic [Y_W-1:0]   y_i,
  output logic             owned_o,
  output logic [DST_W-1:0] dst_o
);
  localparam int unsigned S_W = ((X_W > Y_W) ? X_W : Y_W) + 1;

  logic [S_W-1:0] diag_sum;
  int unsigned    gen_sel;
  int unsigned    col_sel;
  int unsigned    row_sel;

  always_comb begin
    diag_sum = S_W'(x_i) + S_W'(y_i);
    gen_sel  = 32'(diag_sum) % NGEN;
    col_sel  = (32'(x_i) / NGEN) % COLS;
    row_sel  = 32'(y_i) % ROWS;
  end

  assign owned_o = (gen_sel == GEN_ID);
  assign dst_o   = DST_W'(col_sel + COLS * row_sel);
endmodule

// File: rtl/frag_fifo.sv
module frag_fifo #(
  parameter int unsigned WIDTH = 53,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             full_o,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign valid_o = (cnt_q != '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign pop     = valid_o && ready_i;
  assign data_o  = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push_i) wr_d = bump(wr_q);
    if (pop)    rd_d = bump(rd_q);
    case ({push_i, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_q] <= data_i;
  end

  // R5: the router never writes into a full queue
  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);

  // R7: a stalled head stays put
  p_hold_stalled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));
endmodule

// File: rtl/frag_router.sv
module frag_router
  import frag_route_pkg::*;
#(
  parameter int unsigned GEN_ID = 0,
  parameter int unsigned X_W    = FR_X_W,
  parameter int unsigned Y_W    = FR_Y_W,
  parameter int unsigned PAY_W  = FR_PAY_W,
  parameter int unsigned DEPTH  = FR_DEPTH,
  localparam int unsigned NDST   = FR_COLS * FR_ROWS,
  localparam int unsigned DST_W  = (NDST > 1) ? $clog2(NDST) : 1,
  localparam int unsigned FRAG_W = X_W + Y_W + PAY_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   in_valid_i,
  output logic                   in_ready_o,
  input  logic [X_W-1:0]         in_x_i,
  input  logic [Y_W-1:0]         in_y_i,
  input  logic [PAY_W-1:0]       in_pay_i,
  output logic [NDST-1:0]        out_valid_o,
  input  logic [NDST-1:0]        out_ready_i,
  output logic [NDST*FRAG_W-1:0] out_frag_o,
  output logic                   foreign_o
);
  logic             rst_s_n;
  logic             owned;
  logic [DST_W-1:0] dst_idx;
  logic [NDST-1:0]  q_full;
  logic [NDST-1:0]  push_vec;
  logic             accept;
  logic             foreign_d, foreign_q;
  logic [FRAG_W-1:0] in_frag;

  frag_rst_sync u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .srst_no (rst_s_n)
  );

  frag_addr_map #(
    .X_W(X_W), .Y_W(Y_W), .NGEN(FR_GEN_COUNT),
    .COLS(FR_COLS), .ROWS(FR_ROWS), .GEN_ID(GEN_ID)
  ) u_map (
    .x_i     (in_x_i),
    .y_i     (in_y_i),
    .owned_o (owned),
    .dst_o   (dst_idx)
  );

  assign in_frag    = {in_x_i, in_y_i, in_pay_i};
  assign in_ready_o = !owned || !q_full[dst_idx];
  assign accept     = in_valid_i && in_ready_o;

  generate
    for (genvar d = 0; d < NDST; d++) begin : g_dst
      assign push_vec[d] = accept && owned && (dst_idx == DST_W'(d));

      frag_fifo #(.WIDTH(FRAG_W), .DEPTH(DEPTH)) u_q (
        .clk_i   (clk_i),
        .rst_ni  (rst_s_n),
        .push_i  (push_vec[d]),
        .data_i  (in_frag),
        .full_o  (q_full[d]),
        .ready_i (out_ready_i[d]),
        .valid_o (out_valid_o[d]),
        .data_o  (out_frag_o[d*FRAG_W +: FRAG_W])
      );
    end
  endgenerate

  always_comb begin
    foreign_d = accept && !owned;
  end

  always_ff @(posedge clk_i or negedge rst_s_n) begin
    if (!rst_s_n) foreign_q <= 1'b0;
    else          foreign_q <= foreign_d;
  end

  assign foreign_o = foreign_q;

  // R3: an accepted fragment lands in at most one queue
  p_single_dest_r3: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    $onehot0(push_vec));

  // R2: a dropped foreign fragment raises the fault pulse next cycle
  p_fault_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (in_valid_i && in_ready_o && !owned) |=> foreign_o);

  // R8: an owned fragment never raises the fault
  p_no_fault_own_r8: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (in_valid_i && in_ready_o && owned) |=> !foreign_o);

  // R2: a foreign fragment never waits
  p_foreign_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_s_n)
    (in_valid_i && !owned) |-> in_ready_o);
endmodule

// File: tb/tb_frag_router.sv
`timescale 1ns/1ps
module tb_frag_router;
  localparam int GEN  = 0;
  localparam int XW   = 11;
  localparam int YW   = 10;
  localparam int PW   = 32;
  localparam int FW   = XW + YW + PW;
  localparam int ND   = 16;
  localparam int QCAP = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic            in_ready;
  logic [XW-1:0]   in_x;
  logic [YW-1:0]   in_y;
  logic [PW-1:0]   in_pay;
  logic [ND-1:0]   out_valid;
  logic [ND-1:0]   out_ready;
  logic [ND*FW-1:0] out_frag;
  logic            foreign;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  logic [FW-1:0] mq [ND][$];
  bit exp_fault = 0;

  always #2.5 clk = ~clk;

  frag_router #(.GEN_ID(GEN)) dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_x_i(in_x), .in_y_i(in_y), .in_pay_i(in_pay),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_frag_o(out_frag),
    .foreign_o(foreign)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // pick coordinates aimed at output d, owned or foreign
  task automatic pick(input int d, input bit own, output int x, output int y);
    int base;
    y    = 4 * int'($urandom % 200) + d / 4;
    base = 20 * int'($urandom % 90);
    x    = base;
    for (int i = 0; i < 40; i++) begin
      if ((((base + i) / 5) % 4 == d % 4) && ((((base + i) + y) % 5 == GEN) == own)) begin
        x = base + i;
        break;
      end
    end
  endtask

  // one cycle: drive, compare with model, advance model
  task automatic step(input bit v, input int x, input int y, input logic [PW-1:0] p,
                      input logic [ND-1:0] rdy);
    bit own;
    int d;
    bit erdy;
    bit nfault;
    @(negedge clk);
    in_valid  = v;
    in_x      = XW'(x);
    in_y      = YW'(y);
    in_pay    = p;
    out_ready = rdy;
    #1;
    own  = ((x + y) % 5) == GEN;
    d    = ((x / 5) % 4) + 4 * (y % 4);
    erdy = !own || (mq[d].size() < QCAP);
    check(in_ready == erdy, "R5 in_ready", longint'(in_ready), longint'(erdy));
    check(foreign == exp_fault, "R2 R8 fault pulse", longint'(foreign), longint'(exp_fault));
    for (int k = 0; k < ND; k++) begin
      bit ev;
      ev = mq[k].size() != 0;
      check(out_valid[k] == ev, "R3 out_valid", longint'(out_valid[k]), longint'(ev));
      if (ev)
        check(out_frag[k*FW +: FW] == mq[k][0], "R4 out_frag",
              longint'(out_frag[k*FW +: FW]), longint'(mq[k][0]));
    end
    for (int k = 0; k < ND; k++)
      if (mq[k].size() != 0 && rdy[k]) void'(mq[k].pop_front());
    nfault = 0;
    if (v && erdy) begin
      if (own) mq[d].push_back({XW'(x), YW'(y), p});
      else     nfault = 1;
    end
    exp_fault = nfault;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int x, y;
    logic [FW-1:0] held;
    rst_n = 1'b0; in_valid = 0; in_x = '0; in_y = '0; in_pay = '0; out_ready = '0;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == '0, "R1 reset out_valid", longint'(out_valid), 0);
    check(foreign == 1'b0, "R1 reset fault", longint'(foreign), 0);
    check(in_ready == 1'b1, "R1 reset ready", longint'(in_ready), 1);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(0, 0, 0, '0, '1);

    // R3: one owned fragment to each output, stalled so they stay visible
    for (int d = 0; d < ND; d++) begin
      pick(d, 1, x, y);
      step(1, x, y, PW'($urandom), '0);
    end
    step(0, 0, 0, '0, '0);
    check(out_valid == '1, "R3 every output reached", longint'(out_valid), 64'hffff);
    for (int i = 0; i < 3; i++) step(0, 0, 0, '0, '1);

    // R2: foreign fragments interleaved with owned ones
    for (int i = 0; i < 20; i++) begin
      pick(i % ND, i % 2 == 0, x, y);
      step(1, x, y, PW'($urandom), '1);
    end
    step(0, 0, 0, '0, '1);
    step(0, 0, 0, '0, '1);
    check(out_valid == '0, "R2 foreign dropped", longint'(out_valid), 0);

    // R5, R6, R7: fill output 3 while output 7 drains
    for (int i = 0; i < 12; i++) begin
      pick(3, 1, x, y);
      step(1, x, y, PW'($urandom), 16'h0080);
      pick(7, 1, x, y);
      step(1, x, y, PW'($urandom), 16'h0080);
    end
    pick(3, 1, x, y);
    step(1, x, y, PW'($urandom), 16'h0080);
    check(in_ready == 1'b0, "R5 full queue blocks", longint'(in_ready), 0);
    held = out_frag[3*FW +: FW];
    step(0, 0, 0, '0, 16'h0080);
    check(out_valid[7] == 1'b0, "R6 other output drained", longint'(out_valid[7]), 0);
    check(out_frag[3*FW +: FW] == held, "R7 stalled head stable",
          longint'(out_frag[3*FW +: FW]), longint'(held));
    for (int i = 0; i < 12; i++) step(0, 0, 0, '0, '1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      pick(int'($urandom % ND), ($urandom % 5) != 0, x, y);
      step(($urandom % 4) != 0, x, y, PW'($urandom), ND'($urandom));
    end
    for (int i = 0; i < 20; i++) step(0, 0, 0, '0, '1);
    check(out_valid == '0, "R4 all drained", longint'(out_valid), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule